// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of an 8-bit successive-approximation analog-to-digital converter with eight input channels. A start pulse latches a channel number and a clock-rate choice. The block then drives the analog multiplexer select and raises the sample/hold control for a fixed sampling window. After that it resolves one result bit per conversion-clock period, most significant bit first. For each bit it presents a trial code to an external DAC and reads back a single comparator decision. The comparator, DAC and reference sit outside this block.

Every conversion has the same total length, counted in conversion-clock periods. The decisions take only a small part of that length, and the remaining periods are idle. The result is published only when the last period ends. The conversion clock is either the block clock or half of it, chosen by one select input. The block forms this clock as a periodic enable, so the logic never needs a second clock domain.

The result leaves on a valid/ready output. The result is held with `res_valid` high until a handshake (`res_valid && res_ready`) consumes it. There is no back-pressure on the converter: a conversion that ends while an older result is still waiting replaces that result and keeps `res_valid` high.

Top module: `adc_sar_seq`

## Requirements
- R1: When idle, a `start` high at a clock edge makes `busy` go high at that edge. A `start` that arrives while `busy` is high is ignored: the channel, the clock choice, the timing and the result of the running conversion do not change.
- R2: `chan_sel` is captured at the accepted start, and `mux_sel` shows the captured value for the whole of the conversion.
- R3: `sample_hold` is high for exactly 12 conversion-clock periods. These periods start with the first busy cycle. `dac_code` is 00h throughout them.
- R4: Bits are decided most significant first, one per conversion-clock period, starting with the period right after sampling. During the trial of bit k, `dac_code` equals the bits already decided with bit k set and the lower bits clear. Bit k is kept at 1 only if `cmp_in` is 1 at the end of that period, where `cmp_in` = 1 means the input is at or above the trial level.
- R5: A conversion lasts exactly 160 conversion-clock periods. `busy` falls, and `res_data`/`res_valid` update, at the edge that ends the 160th period, and not before.
- R6: With `clk_div_sel` = 0 at start, one conversion-clock period is one clock cycle (160 busy cycles, 12 sampling cycles). With `clk_div_sel` = 1 it is two cycles (320 busy cycles, 24 sampling cycles). The choice is latched at start.
- R7: The result equals the largest 8-bit code that the comparator reports as at or below the input. An all-zero input gives 00h, and a full-scale input gives FFh.
- R8: `res_valid` stays high, with `res_data` unchanged, until a cycle with `res_ready` high. After that cycle it is low. `res_data` changes only when a conversion completes. If a completion and a handshake fall in the same cycle, the completion wins: `res_valid` stays high with the new data.
- R9: After reset, `busy`, `sample_hold` and `res_valid` are 0, and `res_data`, `mux_sel` and `dac_code` are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, acted on only when idle |
| chan_sel | input | 3 | Channel to convert, captured at start |
| clk_div_sel | input | 1 | 0: conversion clock = clk, 1: clk/2; captured at start |
| cmp_in | input | 1 | Comparator decision, 1 when input >= `dac_code` level |
| mux_sel | output | 3 | Analog multiplexer select |
| sample_hold | output | 1 | High while the sample/hold is tracking |
| dac_code | output | 8 | Trial code for the external DAC |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 8 | Conversion result |

## Verification
Two events can fall in one cycle: the handshake that consumes a pending result, and the completion of a new conversion. To provoke this, the bench leaves one result unread, starts a second conversion, and raises `res_ready` exactly in the last busy cycle. It then expects `res_valid` still high, with the second result on `res_data`. A start request placed in the middle of a conversion, with a different channel and clock choice, also checks that the running conversion keeps its own timing and its own channel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_RESOLVE = 2'd2,
    PH_TAIL    = 2'd3
  } adc_phase_e;
endpackage

// File: rtl/adc_clk_tick.sv
// Conversion-clock enable: every cycle, or every second cycle (R6).
module adc_clk_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic half_rate,
  output logic tick
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph_q <= 1'b0;
    else if (!busy)  ph_q <= 1'b0;
    else             ph_q <= ~ph_q;
  end

  // Half rate: the second cycle of each pair closes the period.
  assign tick = busy & (~half_rate | ph_q);
endmodule

// File: rtl/adc_seq_timer.sv
// Period counter, phase decode and one-hot trial bit select.
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS      = 8,
  parameter int CONV_CYCLES   = 160,
  parameter int SAMPLE_CYCLES = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                tick,
  output logic                busy,
  output logic                finish,
  output adc_phase_e          phase,
  output logic [RES_BITS-1:0] trial_mask
);
  localparam int CW          = $clog2(CONV_CYCLES);
  localparam int RESOLVE_END = SAMPLE_CYCLES + RES_BITS;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign finish = busy_q & tick & (cnt_q == LAST); // R5

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (launch) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;                                   // R1
    end else if (finish) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;

  always_comb begin
    if (!busy_q)                               phase = PH_IDLE;
    else if (cnt_q < CW'(SAMPLE_CYCLES))       phase = PH_SAMPLE;   // R3
    else if (cnt_q < CW'(RESOLVE_END))         phase = PH_RESOLVE;
    else                                       phase = PH_TAIL;
  end

  // R4: bit i is under trial in period SAMPLE_CYCLES + (RES_BITS-1-i)
  for (genvar i = 0; i < RES_BITS; i++) begin : g_trial
    assign trial_mask[i] = (phase == PH_RESOLVE) &&
                           (cnt_q == CW'(SAMPLE_CYCLES + RES_BITS - 1 - i));
  end
endmodule

// File: rtl/adc_sar_core.sv
// Successive-approximation register and trial code (R4, R7).
module adc_sar_core #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                tick,
  input  logic [RES_BITS-1:0] trial_mask,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] sar_q,
  output logic [RES_BITS-1:0] dac_code
);
  for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sar_q[i] <= 1'b0;
      else if (launch)                     sar_q[i] <= 1'b0;
      else if (tick && trial_mask[i])      sar_q[i] <= cmp_in;
    end
  end

  // Decided bits plus the bit under test; lower bits are still clear.
  assign dac_code = sar_q | trial_mask;
endmodule

// File: rtl/adc_result_hold.sv
// Result register with valid/ready output (R8, R9).
module adc_result_hold #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                finish,
  input  logic [RES_BITS-1:0] sar_q,
  input  logic                res_ready,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (finish) begin
      res_valid <= 1'b1;            // completion beats a same-cycle handshake
      res_data  <= sar_q;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS      = 8,
  parameter int NUM_CH        = 8,
  parameter int CONV_CYCLES   = 160,
  parameter int SAMPLE_CYCLES = 12,
  localparam int CHW          = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CHW-1:0]      chan_sel,
  input  logic                clk_div_sel,
  input  logic                cmp_in,
  output logic [CHW-1:0]      mux_sel,
  output logic                sample_hold,
  output logic [RES_BITS-1:0] dac_code,
  output logic                busy,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data
);
  logic                launch;
  logic                tick;
  logic                finish;
  logic                half_q;
  logic [CHW-1:0]      chan_q;
  adc_phase_e          phase;
  logic [RES_BITS-1:0] trial_mask;
  logic [RES_BITS-1:0] sar_q;

  // R1: requests while busy are dropped
  assign launch = start & ~busy;

  // R2, R6: channel and rate captured only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      half_q <= 1'b0;
    end else if (launch) begin
      chan_q <= chan_sel;
      half_q <= clk_div_sel;
    end
  end

  adc_clk_tick u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .half_rate (half_q),
    .tick      (tick)
  );

  adc_seq_timer #(
    .RES_BITS      (RES_BITS),
    .CONV_CYCLES   (CONV_CYCLES),
    .SAMPLE_CYCLES (SAMPLE_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .tick       (tick),
    .busy       (busy),
    .finish     (finish),
    .phase      (phase),
    .trial_mask (trial_mask)
  );

  adc_sar_core #(.RES_BITS(RES_BITS)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .tick       (tick),
    .trial_mask (trial_mask),
    .cmp_in     (cmp_in),
    .sar_q      (sar_q),
    .dac_code   (dac_code)
  );

  adc_result_hold #(.RES_BITS(RES_BITS)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .sar_q     (sar_q),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  assign mux_sel     = chan_q;
  assign sample_hold = (phase == PH_SAMPLE);
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
  parameter int RES_BITS    = 8,
  parameter int CHW         = 3,
  parameter int CONV_CYCLES = 160
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                clk_div_sel,
  input logic                busy,
  input logic                sample_hold,
  input logic [CHW-1:0]      mux_sel,
  input logic [RES_BITS-1:0] dac_code,
  input logic                res_valid,
  input logic                res_ready,
  input logic [RES_BITS-1:0] res_data
);
  logic        div_q;
  logic [31:0] run_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= 1'b0;
      run_cyc <= '0;
    end else begin
      if (!busy && start) div_q <= clk_div_sel;
      run_cyc <= busy ? run_cyc + 1 : '0;
    end
  end

  // R2: select frozen while a conversion runs
  p_mux_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mux_sel));

  // R3: no trial code while sampling
  p_sample_dac_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> (busy && dac_code == '0));

  // R5, R6: conversion length in clock cycles
  p_conv_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cyc == (div_q ? 32'(2*CONV_CYCLES) : 32'(CONV_CYCLES)));

  // R5: valid only rises when a conversion ends
  p_valid_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $fell(busy));

  // R8: data only moves at completion
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_data) |-> $fell(busy));

  // R8: handshake clears valid unless a completion lands at once
  p_handshake_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid || $past(busy)));
endmodule

bind adc_sar_seq adc_sar_seq_chk #(
  .RES_BITS    (RES_BITS),
  .CHW         (CHW),
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .clk_div_sel (clk_div_sel),
  .busy        (busy),
  .sample_hold (sample_hold),
  .mux_sel     (mux_sel),
  .dac_code    (dac_code),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data)
);

// File: tb/tb_adc_sar_seq.sv
module tb_adc_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic       clk_div_sel = 1'b0;
  logic       cmp_in;
  logic [2:0] mux_sel;
  logic       sample_hold;
  logic [7:0] dac_code;
  logic       busy;
  logic       res_valid;
  logic       res_ready = 1'b0;
  logic [7:0] res_data;

  logic [7:0] ain [8];
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  // Behavioural comparator: 1 when the selected input is at or above the trial level.
  assign cmp_in = (ain[mux_sel] >= dac_code);

  adc_sar_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .clk_div_sel(clk_div_sel), .cmp_in(cmp_in), .mux_sel(mux_sel),
    .sample_hold(sample_hold), .dac_code(dac_code), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 1'b0,        "R9 busy",        busy, 0);
    chk(sample_hold == 1'b0, "R9 sample_hold", sample_hold, 0);
    chk(res_valid == 1'b0,   "R9 res_valid",   res_valid, 0);
    chk(res_data == 8'h00,   "R9 res_data",    res_data, 0);
    chk(mux_sel == 3'd0,     "R9 mux_sel",     mux_sel, 0);
    chk(dac_code == 8'h00,   "R9 dac_code",    dac_code, 0);
  endtask

  // One conversion; optional mid-run start, optional collision with a handshake.
  task automatic t_convert(input logic [2:0] ch, input logic [7:0] val, input bit div,
                           input bit mid_start, input bit collide, input bit do_read);
    int  i = 0;
    int  sh = 0;
    bit  mux_ok = 1'b1;
    bit  dz_ok = 1'b1;
    bit  t0_seen = 1'b0, t1_seen = 1'b0;
    logic [7:0] t0 = '0, t1 = '0;
    ain[ch] = val;
    @(negedge clk);
    start = 1'b1; chan_sel = ch; clk_div_sel = div;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    while (busy && i < 1000) begin
      int p = div ? (i >> 1) : i;
      if (mux_sel != ch) mux_ok = 1'b0;
      if (sample_hold) begin
        sh++;
        if (dac_code != 8'h00) dz_ok = 1'b0;
      end
      if (p == 12 && !t0_seen) begin t0 = dac_code; t0_seen = 1'b1; end
      if (p == 13 && !t1_seen) begin t1 = dac_code; t1_seen = 1'b1; end
      if (mid_start && i == 50) begin
        start = 1'b1; chan_sel = ~ch; clk_div_sel = ~div;
      end else begin
        start = 1'b0;
      end
      if (collide && i == (div ? 319 : 159)) res_ready = 1'b1;
      i++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(i == (div ? 320 : 160), mid_start ? "R1 length kept" : "R5 R6 busy length", i, div ? 320 : 160);
    chk(sh == (div ? 24 : 12), "R3 R6 sample length", sh, div ? 24 : 12);
    chk(dz_ok, "R3 dac zero while sampling", dz_ok, 1);
    chk(mux_ok, "R2 mux held", mux_sel, ch);
    chk(t0 == 8'h80, "R4 first trial code", t0, 8'h80);
    chk(t1 == {val[7], 7'b1000000}, "R4 second trial code", t1, {val[7], 7'b1000000});
    chk(res_valid == 1'b1, "R5 valid at end", res_valid, 1);
    chk(res_data == val, "R7 result", res_data, val);
    if (collide) begin
      res_ready = 1'b0;
      chk(res_valid == 1'b1 && res_data == val, "R8 completion wins", res_valid, 1);
    end
    if (do_read) begin
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b1 && res_data == val, "R8 held without ready", res_data, val);
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      chk(res_valid == 1'b0, "R8 cleared by handshake", res_valid, 0);
      chk(res_data == val, "R8 data kept", res_data, val);
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) ain[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_convert(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1); // R7 zero
    t_convert(3'd7, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1); // R7 full scale
    t_convert(3'd3, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b1); // R6 half rate
    t_convert(3'd2, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1); // R1 ignored start
    t_convert(3'd5, 8'h81, 1'b0, 1'b0, 1'b0, 1'b0); // leave pending
    t_convert(3'd6, 8'h37, 1'b0, 1'b0, 1'b1, 1'b1); // R8 collision
    t_convert(3'd1, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b1); // R1 R6 mixed
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule